// File: doc/BRIEF.md
# PCI Interrupt Line to Legacy Controller Router

This block steers four level-sensitive PCI interrupt request lines onto the sixteen inputs of a pair of cascaded 8-input legacy interrupt controllers. Each request line has a byte-wide steering register. A value from 0 to 15 names the controller input that the line drives. A value of 16 or more leaves the line unconnected.

The router keeps a level bitmap with one bit for each pair of source line and controller input, 64 bits in the default configuration. Each controller output is the OR of the bits in its own group. The bitmap is a register. On every clock edge it is recomputed in full from the sampled request levels and from the steering values that will hold after that edge. A source level change and a steering write therefore both reach the outputs one cycle later. An edited route also takes effect immediately, and the controller input it used to drive is released.

Software reaches the steering registers through a byte-addressed port with a write strobe and a combinational read.

Top module: `pirq_router`

## Requirements
- R1: After reset every controller output is low, and all four steering registers read 0x80.
- R2: Byte addresses 0x60, 0x61, 0x62 and 0x63 hold the steering registers of source lines 0, 1, 2 and 3 in that order. A read returns, in the same cycle, the full 8-bit value last written.
- R3: When the steering value of a source is below 16, that source's level, sampled at a clock edge, appears on controller output number equal to the steering value after that same edge. It does not appear earlier.
- R4: A controller output is high when any of the four sources steered to it is high. This holds for every combination of the four.
- R5: A source whose steering value is 16 or more drives no controller output, whatever its level.
- R6: A level change on one source alters only the output that source is steered to. All other outputs keep their values.
- R7: After a steering write, the outputs on the following cycle reflect the new routing applied to the current levels, and the previously driven input is released.
- R8: A write to any address outside 0x60 to 0x63 changes no steering register and no output. A read of such an address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the configuration byte port |
| cfg_addr | input | 8 | Byte address for both write and read |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for cfg_addr, combinational |
| src_level | input | 4 | Level of request lines 0 to 3, active high |
| pic_level | output | 16 | Levels driven to controller inputs 0 to 15 |

## Verification
Every output result is due exactly one clock edge after its stimulus. This holds for a source level change and for a steering write alike, because the only register between input and output is the level bitmap. The bench changes inputs on the falling edge and samples at the next falling edge, after the single intervening rising edge. One check samples before that edge to confirm that the old value still holds. Read data is combinational, so it is sampled shortly after the address is applied, with no clock edge in between.

// File: rtl/pirq_route_pkg.sv
package pirq_route_pkg;
    localparam int PR_NUM_SRC = 4;
    localparam int PR_NUM_DST = 16;
    localparam int PR_ADDR_W  = 8;
    localparam int PR_DATA_W  = 8;
    localparam int PR_BASE    = 'h60;
    localparam int PR_RST_VAL = 'h80;

    // Bit position of (destination, source) in the level bitmap
    function automatic int map_index(input int dst, input int src, input int nsrc);
        return dst * nsrc + src;
    endfunction
endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs #(
    parameter int NUM_SRC = 4,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter int BASE    = 'h60,
    parameter int RST_VAL = 'h80
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             cfg_wr,
    input  logic [ADDR_W-1:0]                cfg_addr,
    input  logic [DATA_W-1:0]                cfg_wdata,
    output logic [NUM_SRC-1:0][DATA_W-1:0]   route_q,
    output logic [NUM_SRC-1:0][DATA_W-1:0]   route_d,
    output logic [NUM_SRC-1:0]               wr_hit,
    output logic [DATA_W-1:0]                cfg_rdata
);
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_reg
        assign wr_hit[s]  = cfg_wr && (cfg_addr == ADDR_W'(BASE + s));
        assign route_d[s] = wr_hit[s] ? cfg_wdata : route_q[s];

        always_ff @(posedge clk) begin
            if (rst) route_q[s] <= DATA_W'(RST_VAL);
            else     route_q[s] <= route_d[s];
        end
    end

    always_comb begin
        cfg_rdata = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (cfg_addr == ADDR_W'(BASE + s)) cfg_rdata = route_q[s];
        end
    end
endmodule

// File: rtl/pirq_level_map.sv
module pirq_level_map
    import pirq_route_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int NUM_DST = 16,
    parameter int DATA_W  = 8,
    localparam int MAP_W  = NUM_SRC * NUM_DST
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_SRC-1:0][DATA_W-1:0] route_d,
    input  logic [NUM_SRC-1:0]             src_level,
    output logic [MAP_W-1:0]               map_q
);
    logic [MAP_W-1:0] map_d;

    // Full rebuild each cycle from next-state routing: an out-of-range
    // steering value matches no destination and so records nothing.
    for (genvar d = 0; d < NUM_DST; d++) begin : g_dst
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            assign map_d[map_index(d, s, NUM_SRC)] =
                src_level[s] && (route_d[s] == DATA_W'(d));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) map_q <= '0;
        else     map_q <= map_d;
    end
endmodule

// File: rtl/pirq_pic_merge.sv
module pirq_pic_merge #(
    parameter int NUM_SRC = 4,
    parameter int NUM_DST = 16,
    localparam int MAP_W  = NUM_SRC * NUM_DST
) (
    input  logic [MAP_W-1:0]   map_q,
    output logic [NUM_DST-1:0] pic_level
);
    // OR across the whole group of NUM_SRC bits of each destination
    for (genvar d = 0; d < NUM_DST; d++) begin : g_or
        assign pic_level[d] = |map_q[d*NUM_SRC +: NUM_SRC];
    end
endmodule

// File: rtl/pirq_router.sv
module pirq_router
    import pirq_route_pkg::*;
#(
    parameter int NUM_SRC = PR_NUM_SRC,
    parameter int NUM_DST = PR_NUM_DST,
    parameter int ADDR_W  = PR_ADDR_W,
    parameter int DATA_W  = PR_DATA_W,
    parameter int BASE    = PR_BASE,
    parameter int RST_VAL = PR_RST_VAL,
    localparam int MAP_W  = NUM_SRC * NUM_DST
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_wr,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [DATA_W-1:0]   cfg_wdata,
    output logic [DATA_W-1:0]   cfg_rdata,
    input  logic [NUM_SRC-1:0]  src_level,
    output logic [NUM_DST-1:0]  pic_level
);
    logic [NUM_SRC-1:0][DATA_W-1:0] route_q;
    logic [NUM_SRC-1:0][DATA_W-1:0] route_d;
    logic [NUM_SRC-1:0]             wr_hit;
    logic [MAP_W-1:0]               map_q;

    pirq_route_regs #(
        .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .BASE(BASE), .RST_VAL(RST_VAL)
    ) u_regs (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .route_q(route_q), .route_d(route_d),
        .wr_hit(wr_hit), .cfg_rdata(cfg_rdata)
    );

    pirq_level_map #(
        .NUM_SRC(NUM_SRC), .NUM_DST(NUM_DST), .DATA_W(DATA_W)
    ) u_map (
        .clk(clk), .rst(rst), .route_d(route_d),
        .src_level(src_level), .map_q(map_q)
    );

    pirq_pic_merge #(
        .NUM_SRC(NUM_SRC), .NUM_DST(NUM_DST)
    ) u_merge (
        .map_q(map_q), .pic_level(pic_level)
    );
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
    parameter int NUM_SRC = 4,
    parameter int NUM_DST = 16,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter int BASE    = 'h60,
    parameter int RST_VAL = 'h80
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           cfg_wr,
    input logic [ADDR_W-1:0]              cfg_addr,
    input logic [DATA_W-1:0]              cfg_wdata,
    input logic [NUM_SRC-1:0]             src_level,
    input logic [NUM_DST-1:0]             pic_level,
    input logic [NUM_SRC-1:0][DATA_W-1:0] route_q,
    input logic [NUM_SRC-1:0]             wr_hit
);
    logic [NUM_SRC-1:0] lvl_prev_q;
    logic               run_q;
    logic [NUM_DST-1:0] exp_pic;
    logic               out_range_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_prev_q <= '0;
            run_q      <= 1'b0;
        end else begin
            lvl_prev_q <= src_level;
            run_q      <= 1'b1;
        end
    end

    always_comb begin
        exp_pic = '0;
        for (int d = 0; d < NUM_DST; d++)
            for (int s = 0; s < NUM_SRC; s++)
                if (lvl_prev_q[s] && int'(route_q[s]) == d) exp_pic[d] = 1'b1;
    end

    assign out_range_wr = cfg_wr &&
        ((int'(cfg_addr) < BASE) || (int'(cfg_addr) >= BASE + NUM_SRC));

    // R1: first cycle out of reset
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pic_level == '0 && route_q == {NUM_SRC{DATA_W'(RST_VAL)}}));

    // R3 R4 R5 R6 R7: outputs follow previous-cycle levels under current routing
    assert_pic_or_R4: assert property (@(posedge clk) disable iff (rst)
        run_q |-> pic_level == exp_pic);

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_rb
        // R2: a write lands in the addressed register
        assert_route_write_R2: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(wr_hit[s])) |-> route_q[s] == $past(cfg_wdata));
    end

    // R8: writes outside the routing window leave routing untouched
    assert_foreign_write_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(out_range_wr)) |-> $stable(route_q));
endmodule

bind pirq_router pirq_router_chk #(
    .NUM_SRC(NUM_SRC), .NUM_DST(NUM_DST), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .BASE(BASE), .RST_VAL(RST_VAL)
) u_chk (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .src_level(src_level), .pic_level(pic_level),
    .route_q(route_q), .wr_hit(wr_hit)
);

// File: tb/pirq_router_bench.sv
`timescale 1ns/1ps
module pirq_router_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic [3:0]  src_level = 4'h0;
    logic [15:0] pic_level;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    logic [7:0] m_route [4];
    logic [3:0] m_lvl;

    pirq_router u_pirq_router (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .src_level(src_level), .pic_level(pic_level)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog (all requirements) actual=%0d cycles expected=completion", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [15:0] model_pic();
        logic [15:0] r = '0;
        for (int s = 0; s < 4; s++)
            if (m_lvl[s] && m_route[s] < 8'd16) r[m_route[s][3:0]] = 1'b1;
        return r;
    endfunction

    task automatic chk16(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (a >= 8'h60 && a <= 8'h63) m_route[a - 8'h60] = v;
    endtask

    task automatic set_lvl(input logic [3:0] v);
        @(negedge clk);
        src_level = v; m_lvl = v;
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        cfg_addr = a;
        #1;
        chk8(tag, cfg_rdata, exp);
    endtask

    initial begin
        for (int s = 0; s < 4; s++) m_route[s] = 8'h80;
        m_lvl = 4'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk16("R1 pic after reset", pic_level, 16'h0000);
        for (int s = 0; s < 4; s++) rd(8'(8'h60 + s), 8'h80, "R1 route reset");
        set_lvl(4'hF);
        chk16("R1 R5 reset route disconnects", pic_level, 16'h0000);

        // R2: address order and full-byte readback
        do_write(8'h60, 8'h11);
        do_write(8'h61, 8'h22);
        do_write(8'h62, 8'hA5);
        do_write(8'h63, 8'h0C);
        rd(8'h60, 8'h11, "R2 readback line0");
        rd(8'h61, 8'h22, "R2 readback line1");
        rd(8'h62, 8'hA5, "R2 readback line2");
        rd(8'h63, 8'h0C, "R2 readback line3");
        chk16("R5 R2 only line3 routed", pic_level, 16'h1000);

        // R8: foreign writes and reads
        do_write(8'h5F, 8'h03);
        do_write(8'h64, 8'h04);
        do_write(8'h00, 8'h05);
        for (int s = 0; s < 4; s++) rd(8'(8'h60 + s), m_route[s], "R8 routes unchanged");
        chk16("R8 pic unchanged", pic_level, model_pic());
        rd(8'h64, 8'h00, "R8 read outside");
        rd(8'h5F, 8'h00, "R8 read below");

        // R3: latency of one edge
        set_lvl(4'h0);
        do_write(8'h60, 8'h06);
        @(negedge clk);
        src_level = 4'h1; m_lvl = 4'h1;
        #1;
        chk16("R3 not before edge", pic_level, 16'h0000);
        @(negedge clk);
        chk16("R3 after one edge", pic_level, 16'h0040);

        // R7: re-route releases old destination
        do_write(8'h60, 8'h03);
        chk16("R7 moved to 3", pic_level, 16'h0008);

        // R4: all four lines share destination 9, every combination
        for (int s = 0; s < 4; s++) do_write(8'(8'h60 + s), 8'h09);
        for (int v = 0; v < 16; v++) begin
            set_lvl(4'(v));
            chk16("R4 shared OR", pic_level, (v != 0) ? 16'h0200 : 16'h0000);
        end

        // R5: out-of-range values
        do_write(8'h61, 8'h10);
        do_write(8'h62, 8'hFF);
        set_lvl(4'h6);
        chk16("R5 values 16 and 255 disconnect", pic_level, 16'h0000);

        // R6: one line toggles, others held on distinct outputs
        do_write(8'h60, 8'h00); do_write(8'h61, 8'h05);
        do_write(8'h62, 8'h0A); do_write(8'h63, 8'h0F);
        set_lvl(4'hE);
        chk16("R6 baseline", pic_level, 16'h8420);
        set_lvl(4'hF);
        chk16("R6 line0 rise only bit0", pic_level, 16'h8421);
        set_lvl(4'hB);
        chk16("R6 line2 fall only bit10", pic_level, 16'h8021);

        // Sweep: routings with values 0..19, all level patterns
        for (int c = 0; c < 40; c++) begin
            for (int s = 0; s < 4; s++) begin
                do_write(8'(8'h60 + s), 8'((c * 7 + s * 3 + c / 5) % 20));
                chk16("R7 sweep after write", pic_level, model_pic());
            end
            for (int v = 0; v < 16; v++) begin
                set_lvl(4'(v ^ c));
                chk16("R3 R6 sweep level", pic_level, model_pic());
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule